// File: doc/BRIEF.md
# PLL feedback word calculator

This block is a sequential arithmetic unit that sits beside a frequency synthesizer's control logic. In forward mode it takes a requested output frequency and produces two things: a fixed-point feedback control word and a 3-bit post-divider code. It first limits the request to the highest allowed VCO frequency. It then picks the smallest power-of-two post-divider that lifts the VCO frequency to at least a minimum. Finally it divides the scaled request by the reference frequency. The caller chooses how the word is split into integer and fraction bits by giving the total word width and the integer-part width.

In reverse mode the same unit takes a programmed word and post-divider code and returns the output frequency they produce. Rounding goes upward twice: once when the fraction bits of the VCO product are dropped, and once when the VCO frequency is divided by the post-divider ratio. Both directions share one 64-by-32 restoring divider that yields one quotient bit per clock. A one-cycle start pulse begins each operation, and a one-cycle done pulse marks the moment the results are valid.

Top module: `pll_word_calc`

## Requirements
- R1: After a synchronous active-low reset, result, pdiv_out, err, busy and done are all 0.
- R2: In forward mode (mode = 0) the request is replaced by vco_max when it is larger than vco_max, before any other step.
- R3: In forward mode the exponent is the first value e in the order 0, 1, 2, 3, 4 for which (clamped request × 2^e) ≥ the minimum VCO frequency. When no e qualifies, e is 4. pdiv_out carries e as a 3-bit code, so the divide ratio is 2^pdiv_out.
- R4: A vco_min of 0 stands for a minimum VCO frequency of 1,000,000,000.
- R5: An int_bits of 0 stands for 7 integer bits. The number of fraction bits is tot_bits minus the effective integer bits, or 0 when that difference is negative.
- R6: In forward mode result is the low 32 bits of floor(((request << e) << fraction bits) / ref_freq). The shifts and the division are done in 64-bit unsigned arithmetic.
- R7: In forward mode with ref_freq = 0, err is 1 and result is 0. In every other case err is 0.
- R8: In reverse mode (mode = 1) the VCO value is (ref_freq × word_in) shifted right by the fraction bits, all in 64 bits. One is added when any of the bits shifted out was 1.
- R9: In reverse mode result is the low 32 bits of floor((VCO + 2^pdiv_in − 1) / 2^pdiv_in), and pdiv_out equals pdiv_in.
- R10: A start sampled high while the unit is idle sets busy on the next edge. Exactly 65 clock edges after the edge that sampled start, done is high for one cycle with the results valid, and busy has returned to 0.
- R11: A start that arrives while busy is 1 is ignored. It neither changes the result of the operation in progress nor causes an extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| mode | input | 1 | 0 = frequency to word, 1 = word to frequency |
| freq_in | input | 32 | Requested output frequency (forward) |
| ref_freq | input | 32 | Reference frequency |
| tot_bits | input | 6 | Total feedback word width |
| int_bits | input | 6 | Integer-part width, 0 selects 7 |
| vco_min | input | 32 | Minimum VCO frequency, 0 selects 1,000,000,000 |
| vco_max | input | 32 | Maximum VCO frequency |
| word_in | input | 32 | Programmed feedback word (reverse) |
| pdiv_in | input | 3 | Programmed post-divider code (reverse) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| err | output | 1 | Zero reference in forward mode |
| result | output | 32 | Feedback word (forward) or output frequency (reverse) |
| pdiv_out | output | 3 | Selected (forward) or echoed (reverse) post-divider code |

## Verification
A wrong divider step corrupts the quotient bit by bit. The damage appears in result at the single done pulse, 65 edges after start. A slip in the divider's step counter shows up instead as a done pulse at the wrong edge or a missing one. An error in exponent selection or in the fraction-bit count shows up at that same pulse: pdiv_out is wrong, or result is off by a power of two. The random vectors cover both rounding-up paths in reverse mode. The directed vectors cover the clamp, both defaults, the case where no exponent qualifies, the zero reference and a start given while busy.

// File: rtl/pwc_pkg.sv
// Shared definitions for the PLL feedback word calculator.
// Assumes frequencies and words fit the 32-bit datapath width.
package pwc_pkg;
    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_REV = 1'b1
    } pwc_mode_e;
endpackage

// File: rtl/pwc_prep.sv
// Operand preparation: combinational front end of the calculator.
// Forward: clamps the request, searches for the post-divider exponent and
// builds the scaled dividend with the reference as divisor.
// Reverse: forms the rounded-up VCO value and biases it for a ceiling
// divide by the post-divider ratio.
// Assumes tot_bits/int_bits no wider than CW and frequencies FW bits wide.
module pwc_prep #(
    parameter int FW        = 32,
    parameter int CW        = 6,
    parameter int PDW       = 3,
    parameter int EXP_MAX   = 4,
    parameter int DEF_IBITS = 7,
    parameter logic [FW-1:0] DEF_VMIN = 32'd1_000_000_000
) (
    input  logic           mode,
    input  logic [FW-1:0]  freq_in,
    input  logic [FW-1:0]  ref_freq,
    input  logic [CW-1:0]  tot_bits,
    input  logic [CW-1:0]  int_bits,
    input  logic [FW-1:0]  vco_min,
    input  logic [FW-1:0]  vco_max,
    input  logic [FW-1:0]  word_in,
    input  logic [PDW-1:0] pdiv_in,
    output logic [2*FW-1:0] dividend,
    output logic [FW-1:0]  divisor,
    output logic [PDW-1:0] pdiv_sel,
    output logic           ref_zero
);
    localparam int NW = 2 * FW;

    logic [CW-1:0]  ib_eff;
    logic [CW-1:0]  frac_bits;
    logic [FW-1:0]  f_clamp;
    logic [FW-1:0]  vmin_eff;
    logic [PDW-1:0] exp_sel;
    logic           found;
    logic [NW-1:0]  prod;
    logic [NW-1:0]  drop_mask;
    logic [NW-1:0]  vco;
    logic [NW-1:0]  ratio;

    // Fraction-bit count from the width inputs with the integer default.
    always_comb begin
        ib_eff    = (int_bits == '0) ? CW'(DEF_IBITS) : int_bits;
        frac_bits = (tot_bits > ib_eff) ? (tot_bits - ib_eff) : '0;
    end

    // Clamp and exponent search, first qualifying exponent wins.
    always_comb begin
        f_clamp  = (freq_in > vco_max) ? vco_max : freq_in;
        vmin_eff = (vco_min == '0) ? DEF_VMIN : vco_min;
        exp_sel  = PDW'(EXP_MAX);
        found    = 1'b0;
        for (int e = 0; e <= EXP_MAX; e++) begin
            if (!found && ((NW'(f_clamp) << e) >= NW'(vmin_eff))) begin
                exp_sel = PDW'(e);
                found   = 1'b1;
            end
        end
    end

    // Reverse path: product, drop fraction bits rounding up.
    always_comb begin
        prod      = NW'(ref_freq) * NW'(word_in);
        drop_mask = (NW'(1) << frac_bits) - NW'(1);
        vco       = (prod >> frac_bits) + NW'((prod & drop_mask) != '0);
        ratio     = NW'(1) << pdiv_in;
    end

    // Operand select for the shared divider.
    always_comb begin
        if (mode == pwc_pkg::MODE_FWD) begin
            dividend = (NW'(f_clamp) << exp_sel) << frac_bits;
            divisor  = ref_freq;
            pdiv_sel = exp_sel;
        end else begin
            dividend = vco + ratio - NW'(1);
            divisor  = ratio[FW-1:0];
            pdiv_sel = pdiv_in;
        end
        ref_zero = (ref_freq == '0);
    end
endmodule

// File: rtl/pwc_divider.sv
// Restoring divider, NW-bit dividend by DW-bit divisor, one quotient bit
// per clock, MSB first. load starts a run; done pulses for one cycle on the
// edge that produces the last bit. A zero divisor gives an all-ones
// quotient; the caller must handle that case itself.
module pwc_divider #(
    parameter int NW = 64,
    parameter int DW = 32,
    parameter int OW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [OW-1:0] quot_lo
);
    localparam int CNTW = $clog2(NW + 1);

    logic [NW-1:0]   quot;
    logic [DW:0]     rem;
    logic [DW-1:0]   dvsr;
    logic [CNTW-1:0] cnt;
    logic            run;
    logic [DW:0]     rem_sh;
    logic            fits;

    // Shift-and-compare for the next quotient bit.
    always_comb begin
        rem_sh = {rem[DW-1:0], quot[NW-1]};
        fits   = (rem_sh >= {1'b0, dvsr});
    end

    // Iteration registers and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot <= '0;
            rem  <= '0;
            dvsr <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (load) begin
            quot <= dividend;
            rem  <= '0;
            dvsr <= divisor;
            cnt  <= CNTW'(NW);
            run  <= 1'b1;
            done <= 1'b0;
        end else if (run) begin
            quot <= {quot[NW-2:0], fits};
            rem  <= fits ? (rem_sh - {1'b0, dvsr}) : rem_sh;
            cnt  <= cnt - CNTW'(1);
            run  <= (cnt != CNTW'(1));
            done <= (cnt == CNTW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    assign quot_lo = quot[OW-1:0];

    // R10: the divider's completion is a single-cycle pulse
    p_div_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: completion only comes out of a running divide
    p_div_done_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));
endmodule

// File: rtl/pll_word_calc.sv
// PLL feedback word calculator, top level.
// Accepts start while idle, captures prepared operands into the shared
// divider, and registers the results when the divider finishes.
// done pulses NW+1 edges after the accepted start.
// Assumes inputs are held only during the start cycle.
module pll_word_calc #(
    parameter int FW        = 32,
    parameter int CW        = 6,
    parameter int PDW       = 3,
    parameter int EXP_MAX   = 4,
    parameter int DEF_IBITS = 7,
    parameter logic [FW-1:0] DEF_VMIN = 32'd1_000_000_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           mode,
    input  logic [FW-1:0]  freq_in,
    input  logic [FW-1:0]  ref_freq,
    input  logic [CW-1:0]  tot_bits,
    input  logic [CW-1:0]  int_bits,
    input  logic [FW-1:0]  vco_min,
    input  logic [FW-1:0]  vco_max,
    input  logic [FW-1:0]  word_in,
    input  logic [PDW-1:0] pdiv_in,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [FW-1:0]  result,
    output logic [PDW-1:0] pdiv_out
);
    localparam int NW = 2 * FW;

    logic [NW-1:0]  dividend;
    logic [FW-1:0]  divisor;
    logic [PDW-1:0] pdiv_sel;
    logic           ref_zero;
    logic           accept;
    logic           div_done;
    logic [FW-1:0]  quot_lo;
    logic           mode_q;
    logic           zero_q;
    logic [PDW-1:0] pdiv_q;

    assign accept = start && !busy;

    pwc_prep #(
        .FW(FW), .CW(CW), .PDW(PDW), .EXP_MAX(EXP_MAX),
        .DEF_IBITS(DEF_IBITS), .DEF_VMIN(DEF_VMIN)
    ) u_prep (
        .mode(mode), .freq_in(freq_in), .ref_freq(ref_freq),
        .tot_bits(tot_bits), .int_bits(int_bits),
        .vco_min(vco_min), .vco_max(vco_max),
        .word_in(word_in), .pdiv_in(pdiv_in),
        .dividend(dividend), .divisor(divisor),
        .pdiv_sel(pdiv_sel), .ref_zero(ref_zero)
    );

    pwc_divider #(.NW(NW), .DW(FW), .OW(FW)) u_div (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .dividend(dividend), .divisor(divisor),
        .done(div_done), .quot_lo(quot_lo)
    );

    // Operation control and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            result   <= '0;
            pdiv_out <= '0;
            mode_q   <= 1'b0;
            zero_q   <= 1'b0;
            pdiv_q   <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            mode_q <= mode;
            zero_q <= ref_zero;
            pdiv_q <= pdiv_sel;
        end else if (busy && div_done) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            pdiv_out <= pdiv_q;
            if (mode_q == pwc_pkg::MODE_FWD && zero_q) begin
                err    <= 1'b1;
                result <= '0;
            end else begin
                err    <= 1'b0;
                result <= quot_lo;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R10: an accepted start raises busy on the next edge
    p_start_sets_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10: done is one cycle wide and never overlaps busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: a flagged error always carries a zero word
    p_err_zero_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (result == '0));
    // R3: forward results never carry an exponent above the search limit
    p_pdiv_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> (pdiv_out <= PDW'(EXP_MAX)));
    // R11: results stay put while an operation is in flight
    p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(result) && $stable(err)));
endmodule

// File: tb/pll_word_calc_test.sv
module pll_word_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] freq_in = '0, ref_freq = '0, vco_min = '0, vco_max = '0, word_in = '0;
    logic [5:0]  tot_bits = '0, int_bits = '0;
    logic [2:0]  pdiv_in = '0;
    logic        busy, done, err;
    logic [31:0] result;
    logic [2:0]  pdiv_out;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    pll_word_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .freq_in(freq_in), .ref_freq(ref_freq), .tot_bits(tot_bits),
        .int_bits(int_bits), .vco_min(vco_min), .vco_max(vco_max),
        .word_in(word_in), .pdiv_in(pdiv_in), .busy(busy), .done(done),
        .err(err), .result(result), .pdiv_out(pdiv_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int frac_of(input logic [5:0] tb, input logic [5:0] ib);
        int i = (ib == 0) ? 7 : int'(ib);
        return (int'(tb) > i) ? int'(tb) - i : 0;
    endfunction

    function automatic int exp_of(input logic [31:0] f, input logic [31:0] vmin,
                                  input logic [31:0] vmax);
        longint unsigned fc = (f > vmax) ? vmax : f;
        longint unsigned mn = (vmin == 0) ? 64'd1_000_000_000 : 64'(vmin);
        for (int e = 0; e < 5; e++)
            if ((fc << e) >= mn) return e;
        return 4;
    endfunction

    function automatic logic [31:0] fwd_word(input logic [31:0] f, input logic [31:0] rf,
            input logic [31:0] vmin, input logic [31:0] vmax,
            input logic [5:0] tb, input logic [5:0] ib);
        longint unsigned fc = (f > vmax) ? vmax : f;
        longint unsigned n;
        if (rf == 0) return 32'd0;
        n = (fc << exp_of(f, vmin, vmax)) << frac_of(tb, ib);
        return 32'(n / 64'(rf));
    endfunction

    function automatic logic [31:0] rev_freq(input logic [31:0] rf, input logic [31:0] w,
            input logic [5:0] tb, input logic [5:0] ib, input logic [2:0] pd);
        longint unsigned p = 64'(rf) * 64'(w);
        int fb = frac_of(tb, ib);
        longint unsigned m = (64'd1 << fb) - 64'd1;
        longint unsigned v = (p >> fb) + (((p & m) != 0) ? 64'd1 : 64'd0);
        longint unsigned r = 64'd1 << pd;
        return 32'((v + r - 64'd1) / r);
    endfunction

    // Runs one operation; optionally pokes start mid-run.
    task automatic run_op(input string tag, input logic md, input logic [31:0] f,
            input logic [31:0] rf, input logic [5:0] tb, input logic [5:0] ib,
            input logic [31:0] vmn, input logic [31:0] vmx, input logic [31:0] w,
            input logic [2:0] pd, input bit poke);
        logic [31:0] exp_r;
        logic [2:0]  exp_p;
        logic        exp_e;
        int n = 0;
        int dones = 0;
        if (md == 1'b0) begin
            exp_r = fwd_word(f, rf, vmn, vmx, tb, ib);
            exp_p = 3'(exp_of(f, vmn, vmx));
            exp_e = (rf == 0);
        end else begin
            exp_r = rev_freq(rf, w, tb, ib, pd);
            exp_p = pd;
            exp_e = 1'b0;
        end
        @(negedge clk);
        mode = md; freq_in = f; ref_freq = rf; tot_bits = tb; int_bits = ib;
        vco_min = vmn; vco_max = vmx; word_in = w; pdiv_in = pd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        while (!done && n < 200) begin
            if (poke && n == 20) begin
                start = 1'b1; mode = ~md; freq_in = ~f; ref_freq = rf + 32'd7;
                word_in = ~w; pdiv_in = ~pd;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
            if (done) dones++;
        end
        start = 1'b0;
        check(n == 65, "R10 latency", 64'(n), 64'd65);
        check(result == exp_r, tag, 64'(result), 64'(exp_r));
        check(pdiv_out == exp_p, md ? "R9 pdiv echo" : "R3 pdiv code", 64'(pdiv_out), 64'(exp_p));
        check(err == exp_e, "R7 err flag", 64'(err), 64'(exp_e));
        check(busy == 1'b0, "R10 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        if (poke) begin
            for (int k = 0; k < 70; k++) begin
                @(negedge clk);
                if (done) dones++;
            end
            check(dones == 1, "R11 no extra done", 64'(dones), 64'd1);
            check(result == exp_r, "R11 result kept", 64'(result), 64'(exp_r));
        end
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        check(1'b0, "watchdog", 64'(cycles), 64'd150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({busy, done, err, result, pdiv_out} == '0, "R1 reset state",
              64'({busy, done, err, result, pdiv_out}), 64'd0);
        rst_n = 1'b1;
        // Directed corner cases
        run_op("R6 typical word", 0, 32'd1_500_000_000, 32'd26_000_000, 6'd22, 6'd7,
               32'd0, 32'd3_800_000_000, 0, 0, 0);
        run_op("R4 default vmin", 0, 32'd300_000_000, 32'd26_000_000, 6'd31, 6'd0,
               32'd0, 32'd3_800_000_000, 0, 0, 0);
        run_op("R3 explicit vmin", 0, 32'd300_000_000, 32'd40_000_000, 6'd24, 6'd8,
               32'd500_000_000, 32'd3_000_000_000, 0, 0, 0);
        run_op("R2 clamp to max", 0, 32'd4_000_000_000, 32'd25_000_000, 6'd20, 6'd7,
               32'd0, 32'd3_000_000_000, 0, 0, 0);
        run_op("R3 none qualifies", 0, 32'd10_000_000, 32'd26_000_000, 6'd24, 6'd7,
               32'd0, 32'd3_000_000_000, 0, 0, 0);
        run_op("R5 negative fraction", 0, 32'd2_600_000_000, 32'd26_000_000, 6'd5, 6'd0,
               32'd0, 32'd3_000_000_000, 0, 0, 0);
        run_op("R7 zero reference", 0, 32'd1_200_000_000, 32'd0, 6'd22, 6'd7,
               32'd0, 32'd3_000_000_000, 0, 0, 0);
        run_op("R8 exact vco", 1, 0, 32'd25_000_000, 6'd10, 6'd7, 0, 0, 32'd480, 3'd0, 0);
        run_op("R8 fraction round up", 1, 0, 32'd26_000_000, 6'd22, 6'd7, 0, 0,
               32'd3_000_001, 3'd1, 0);
        run_op("R9 divide round up", 1, 0, 32'd26_000_001, 6'd7, 6'd7, 0, 0,
               32'd101, 3'd7, 0);
        run_op("R11 start while busy", 0, 32'd1_100_000_000, 32'd20_000_000, 6'd30, 6'd9,
               32'd0, 32'd3_500_000_000, 0, 0, 1);
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic md = 1'($urandom);
            logic [31:0] rf = 32'd1_000_000 + ($urandom % 32'd60_000_000);
            logic [31:0] f = $urandom;
            logic [31:0] vmn = ($urandom % 4 == 0) ? 32'd0 : ($urandom % 32'd2_000_000_000);
            logic [31:0] vmx = 32'd500_000_000 + ($urandom % 32'd3_500_000_000);
            logic [5:0]  tb = 6'($urandom % 40);
            logic [5:0]  ib = 6'($urandom % 13);
            run_op(md ? "R9 random reverse" : "R6 random forward", md, f, rf, tb, ib,
                   vmn, vmx, $urandom, 3'($urandom), 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule